// File: doc/BRIEF.md
# Microcoded Coprocessor Sequencer with Register File

This block is the control half of a small serial cipher coprocessor. A program counter walks through a 1K-entry instruction store. Each entry is a flat 14-bit control word. Its fields drive the two register-file addresses, the port-B write-back enable and three datapath steering bits in the same cycle the word is read, with no decoding stage. The host picks one of two routines. The init command runs the key-setup routine, which starts at address 0. The start command runs one encryption, which starts at a parameterized base address placed after the setup code. A ready flag rises once the routine has finished.

The block also holds a 32 x 16 dual-port register file. It keeps the plaintext, the sixteen key words, the four state words, a hard-wired zero word and scratch words. Its contents are kept between routines, so the host only reloads the plaintext before the next encryption and reads the result back through the user port once the sequencer is idle. The arithmetic datapath sits outside the block. It receives the two read words and the steering bits, and it returns one result word that is written through port B.

Top module: `hbCoprocSeq`

## Requirements
- R1: A control word is laid out as follows: bit 13 is the port-B write enable, bits 12:8 are the port-A address, bits 7:3 are the port-B address, and bits 2:0 are the steering bits (bit 0 is steering bit 0). While busy, the word at the current program address drives `dpA` = reg[port-A address], `dpB` = reg[port-B address] and `dpCtrl` = steering bits, all in the same cycle. While idle, `dpB` and `dpCtrl` are 0.
- R2: An init command taken while idle executes INIT_LEN (312) consecutive words starting at address 0, and `busy` stays high for exactly INIT_LEN cycles.
- R3: A start command taken while idle executes ENC_LEN (75) consecutive words starting at ENC_BASE (512), and `busy` stays high for exactly ENC_LEN cycles.
- R4: When init and start arrive in the same idle cycle, init is taken.
- R5: `ready` goes to 0 in the cycle after a command is taken. It goes to 1 in the cycle after the last word of a routine. It then holds until the next command is taken, and it is never 1 while `busy` is high.
- R6: init and start are ignored while busy, including during the final cycle of a routine.
- R7: When a word's write enable is 1, `dpResult` is stored at that word's port-B address at the end of the cycle, and the following words see the new value.
- R8: A user write (`usrWe`) is stored only while idle. A user write issued while busy is dropped.
- R9: While idle, `usrRdata` equals reg[`usrAddr`] in the same cycle. While busy it is 0.
- R10: Address 0 always reads as 0, and writes to it from either port are dropped.
- R11: The register contents survive from one routine to the next, so a second encryption needs only a new plaintext word.
- R12: Instruction-store writes (`imemWe`) are accepted only while idle.
- R13: After reset, `busy`, `ready`, `dpB` and `dpCtrl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdInit | input | 1 | Run the setup routine |
| cmdStart | input | 1 | Run one encryption |
| busy | output | 1 | A routine is executing |
| ready | output | 1 | The last routine has finished |
| imemWe | input | 1 | Instruction-store write strobe |
| imemAddr | input | 10 | Instruction-store write address |
| imemData | input | 14 | Control word to store |
| usrWe | input | 1 | Register write from the user port |
| usrAddr | input | 5 | User port register address |
| usrWdata | input | 16 | User port write data |
| usrRdata | output | 16 | User port read data |
| dpA | output | 16 | Port-A read word to the datapath |
| dpB | output | 16 | Port-B read word to the datapath |
| dpCtrl | output | 3 | Datapath steering bits |
| dpResult | input | 16 | Datapath result, written back through port B |

## Verification
Two events can fall in the same cycle. The first collision is a new command arriving in the final cycle of a routine, when the sequencer is finishing but has not yet dropped busy. The second is a user write or an instruction-store write colliding with a running routine. The bench raises start exactly on the last busy cycle, and raises start, a register write and a control-word write in the middle of setup. A per-cycle reference model decides each outcome: the routine length must not change, busy must fall and stay low, and both the register and the later-fetched control word must keep their old values.

// File: rtl/hbSeqPkg.sv
package hbSeqPkg;
  parameter int RF_AW  = 5;
  parameter int DATA_W = 16;
  parameter int CTRL_W = 3;

  // Flat control word: field order fixes bit positions 13 / 12:8 / 7:3 / 2:0.
  typedef struct packed {
    logic              wbEn;
    logic [RF_AW-1:0]  addrA;
    logic [RF_AW-1:0]  addrB;
    logic [CTRL_W-1:0] ctrl;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // Strobes from the control half to the register-file half.
  typedef struct packed {
    logic             weA;
    logic             weB;
    logic [RF_AW-1:0] addrA;
    logic [RF_AW-1:0] addrB;
  } rfStrobe_t;
endpackage

// File: rtl/hbSeqCtrl.sv
module hbSeqCtrl
  import hbSeqPkg::*;
#(
  parameter int IMEM_DEPTH = 1024,
  parameter int INIT_LEN   = 312,
  parameter int ENC_BASE   = 512,
  parameter int ENC_LEN    = 75,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int MAX_LEN   = (INIT_LEN > ENC_LEN) ? INIT_LEN : ENC_LEN,
  localparam int CNT_W     = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdInit,
  input  logic               cmdStart,
  input  logic               imemWe,
  input  logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  input  logic               usrWe,
  input  logic [RF_AW-1:0]   usrAddr,
  output rfStrobe_t          rfStb,
  output logic [CTRL_W-1:0]  dpCtrl,
  output logic               busy,
  output logic               ready
);
  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [PC_W-1:0]    pc;
  logic [CNT_W-1:0]   stepCnt;
  logic [CNT_W-1:0]   lastStep;
  instr_t             cur;
  logic               takeCmd;

  assign cur     = instr_t'(imem[pc]);
  assign takeCmd = !busy && (cmdInit || cmdStart);

  always_ff @(posedge clk) begin
    if (imemWe && !busy) imem[imemAddr] <= imemData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      ready    <= 1'b0;
      pc       <= '0;
      stepCnt  <= '0;
      lastStep <= '0;
    end else if (takeCmd) begin
      busy     <= 1'b1;
      ready    <= 1'b0;
      stepCnt  <= '0;
      pc       <= cmdInit ? '0 : PC_W'(ENC_BASE);
      lastStep <= cmdInit ? CNT_W'(INIT_LEN - 1) : CNT_W'(ENC_LEN - 1);
    end else if (busy) begin
      if (stepCnt == lastStep) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end else begin
        pc      <= pc + PC_W'(1);
        stepCnt <= stepCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    rfStb.weA   = usrWe && !busy;
    rfStb.addrA = busy ? cur.addrA : usrAddr;
    rfStb.weB   = busy && cur.wbEn;
    rfStb.addrB = busy ? cur.addrB : '0;
    dpCtrl      = busy ? cur.ctrl : '0;
  end
endmodule

// File: rtl/hbRegFile.sv
module hbRegFile
  import hbSeqPkg::*;
#(
  parameter int ZERO_ADDR = 0,
  localparam int DEPTH    = 1 << RF_AW
) (
  input  logic              clk,
  input  rfStrobe_t         rfStb,
  input  logic [DATA_W-1:0] wdA,
  input  logic [DATA_W-1:0] wdB,
  output logic [DATA_W-1:0] rdA,
  output logic [DATA_W-1:0] rdB
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rfStb.weA && rfStb.addrA != RF_AW'(ZERO_ADDR)) mem[rfStb.addrA] <= wdA;
    if (rfStb.weB && rfStb.addrB != RF_AW'(ZERO_ADDR)) mem[rfStb.addrB] <= wdB;
  end

  assign rdA = (rfStb.addrA == RF_AW'(ZERO_ADDR)) ? '0 : mem[rfStb.addrA];
  assign rdB = (rfStb.addrB == RF_AW'(ZERO_ADDR)) ? '0 : mem[rfStb.addrB];
endmodule

// File: rtl/hbCoprocSeq.sv
module hbCoprocSeq
  import hbSeqPkg::*;
#(
  parameter int IMEM_DEPTH = 1024,
  parameter int INIT_LEN   = 312,
  parameter int ENC_BASE   = 512,
  parameter int ENC_LEN    = 75
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdInit,
  input  logic                          cmdStart,
  output logic                          busy,
  output logic                          ready,
  input  logic                          imemWe,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imemAddr,
  input  logic [INSTR_W-1:0]            imemData,
  input  logic                          usrWe,
  input  logic [RF_AW-1:0]              usrAddr,
  input  logic [DATA_W-1:0]             usrWdata,
  output logic [DATA_W-1:0]             usrRdata,
  output logic [DATA_W-1:0]             dpA,
  output logic [DATA_W-1:0]             dpB,
  output logic [CTRL_W-1:0]             dpCtrl,
  input  logic [DATA_W-1:0]             dpResult
);
  rfStrobe_t rfStb;

  hbSeqCtrl #(
    .IMEM_DEPTH(IMEM_DEPTH), .INIT_LEN(INIT_LEN),
    .ENC_BASE(ENC_BASE), .ENC_LEN(ENC_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdInit(cmdInit), .cmdStart(cmdStart),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .usrWe(usrWe), .usrAddr(usrAddr), .rfStb(rfStb), .dpCtrl(dpCtrl),
    .busy(busy), .ready(ready)
  );

  hbRegFile #(.ZERO_ADDR(0)) u_rf (
    .clk(clk), .rfStb(rfStb), .wdA(usrWdata), .wdB(dpResult),
    .rdA(dpA), .rdB(dpB)
  );

  assign usrRdata = busy ? '0 : dpA;
endmodule

// File: rtl/hbCoprocSeq_chk.sv
module hbCoprocSeq_chk
  import hbSeqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdInit,
  input logic              cmdStart,
  input logic              busy,
  input logic              ready,
  input logic [RF_AW-1:0]  addrA,
  input logic [DATA_W-1:0] rdA
);
  assert_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (cmdInit || cmdStart)) |=> (busy && !ready));

  assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ready);

  assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !cmdInit && !cmdStart) |=> ready);

  assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ready);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdInit && !cmdStart) |=> !busy);

  assert_zero_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    (addrA == '0) |-> (rdA == '0));
endmodule

bind hbCoprocSeq hbCoprocSeq_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdInit(cmdInit), .cmdStart(cmdStart),
  .busy(busy), .ready(ready), .addrA(rfStb.addrA), .rdA(dpA)
);

// File: tb/hbCoprocSeq_tb.sv
module hbCoprocSeq_tb;
  localparam int INIT_LEN = 312;
  localparam int ENC_BASE = 512;
  localparam int ENC_LEN  = 75;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdInit = 0, cmdStart = 0, imemWe = 0, usrWe = 0;
  logic [9:0]  imemAddr = '0;
  logic [13:0] imemData = '0;
  logic [4:0]  usrAddr = '0;
  logic [15:0] usrWdata = '0;
  logic        busy, ready;
  logic [15:0] usrRdata, dpA, dpB, dpResult;
  logic [2:0]  dpCtrl;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [15:0] rfm [32];
  logic [13:0] imm [1024];
  logic        mBusy = 0, mReady = 0;
  int          mPc = 0, mCnt = 0, mLast = 0;

  always #5 clk = ~clk;

  // datapath stub
  assign dpResult = (dpA + dpB) ^ {13'b0, dpCtrl};

  hbCoprocSeq u_dut (
    .clk(clk), .rstN(rstN), .cmdInit(cmdInit), .cmdStart(cmdStart),
    .busy(busy), .ready(ready), .imemWe(imemWe), .imemAddr(imemAddr),
    .imemData(imemData), .usrWe(usrWe), .usrAddr(usrAddr),
    .usrWdata(usrWdata), .usrRdata(usrRdata), .dpA(dpA), .dpB(dpB),
    .dpCtrl(dpCtrl), .dpResult(dpResult)
  );

  function automatic logic [13:0] progWord(int a);
    logic [4:0] fa = 5'((a * 7 + 3) % 32);
    logic [4:0] fb = 5'((a * 5 + 1) % 32);
    return {(a % 3) != 0, fa, fb, 3'(a % 8)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model with the current inputs, advance the model, step a clock.
  task automatic tick();
    logic [13:0] w;
    logic [4:0]  eA, eB;
    logic [2:0]  eC;
    logic [15:0] eDa, eDb, res;
    #1;
    w   = imm[mPc];
    eA  = mBusy ? w[12:8] : usrAddr;
    eB  = mBusy ? w[7:3] : 5'd0;
    eC  = mBusy ? w[2:0] : 3'd0;
    eDa = (eA == 0) ? 16'd0 : rfm[eA];
    eDb = (eB == 0) ? 16'd0 : rfm[eB];
    chk("R3 busy", int'(busy), int'(mBusy));
    chk("R5 ready", int'(ready), int'(mReady));
    chk("R1 dpA", int'(dpA), int'(eDa));
    chk("R1 dpB", int'(dpB), int'(eDb));
    chk("R1 dpCtrl", int'(dpCtrl), int'(eC));
    chk("R9 usrRdata", int'(usrRdata), mBusy ? 0 : int'(eDa));
    res = (eDa + eDb) ^ {13'b0, eC};
    if (mBusy) begin
      if (w[13] && eB != 0) rfm[eB] = res;
      if (mCnt == mLast) begin
        mBusy = 0; mReady = 1;
      end else begin
        mPc++; mCnt++;
      end
    end else begin
      if (imemWe) imm[imemAddr] = imemData;
      if (usrWe && usrAddr != 0) rfm[usrAddr] = usrWdata;
      if (cmdInit || cmdStart) begin
        mBusy = 1; mReady = 0; mCnt = 0;
        mPc   = cmdInit ? 0 : ENC_BASE;
        mLast = cmdInit ? INIT_LEN - 1 : ENC_LEN - 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readRf(int a, string tag);
    usrAddr = 5'(a);
    #1;
    chk(tag, int'(usrRdata), (a == 0) ? 0 : int'(rfm[a]));
  endtask

  task automatic writeRf(int a, logic [15:0] v);
    usrWe = 1; usrAddr = 5'(a); usrWdata = v;
    tick();
    usrWe = 0;
  endtask

  initial begin
    int n;
    for (int i = 0; i < 32; i++) rfm[i] = '0;
    for (int i = 0; i < 1024; i++) imm[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 busy", int'(busy), 0);
    chk("R13 ready", int'(ready), 0);
    chk("R13 dpB", int'(dpB), 0);
    chk("R13 dpCtrl", int'(dpCtrl), 0);
    rstN = 1;
    @(negedge clk);

    // preload the instruction store
    for (int a = 0; a < 1024; a++) begin
      imemWe = 1; imemAddr = 10'(a); imemData = progWord(a);
      tick();
    end
    imemWe = 0;

    // key, state and plaintext words; a write to the zero word is dropped
    for (int a = 1; a < 32; a++) writeRf(a, 16'(a * 16'h0731 + 16'h1111));
    writeRf(0, 16'hBEEF);
    readRf(0, "R10 zero word");
    readRf(7, "R8 idle write");

    // init and start together; collisions injected mid-routine
    cmdInit = 1; cmdStart = 1;
    tick();
    cmdInit = 0; cmdStart = 0;
    n = 0;
    while (busy && n < 2000) begin
      n++;
      if (n == 100) begin
        cmdStart = 1; usrWe = 1; usrAddr = 5'd9; usrWdata = 16'h5A5A;
        imemWe = 1; imemAddr = 10'(ENC_BASE); imemData = progWord(ENC_BASE) ^ 14'h7;
      end
      tick();
      cmdStart = 0; usrWe = 0; imemWe = 0;
    end
    chk("R4 init wins, length", n, INIT_LEN);
    chk("R6 start while busy ignored", n, INIT_LEN);
    chk("R5 ready after init", int'(ready), 1);
    readRf(9, "R8 busy write dropped");

    // encryption
    cmdStart = 1;
    tick();
    cmdStart = 0;
    #1;
    chk("R12 busy imem write dropped", int'(dpCtrl), int'(progWord(ENC_BASE) & 14'h7));
    n = 0;
    while (busy && n < 2000) begin
      n++;
      tick();
    end
    chk("R3 encryption length", n, ENC_LEN);
    for (int a = 0; a < 32; a++) readRf(a, "R7 write-back result");

    // second encryption: only the plaintext word changes; start on the final cycle
    writeRf(1, 16'hC0DE);
    cmdStart = 1;
    tick();
    cmdStart = 0;
    n = 0;
    while (busy && n < 2000) begin
      n++;
      if (n == ENC_LEN) cmdStart = 1;
      tick();
      cmdStart = 0;
    end
    chk("R6 final-cycle start ignored", int'(busy), 0);
    chk("R11 second run length", n, ENC_LEN);
    for (int a = 0; a < 32; a++) readRf(a, "R11 persisted words");

    // init alone
    cmdInit = 1;
    tick();
    cmdInit = 0;
    n = 0;
    while (busy && n < 2000) begin
      n++;
      tick();
    end
    chk("R2 init length", n, INIT_LEN);
    readRf(0, "R10 zero word after run");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule